// File: doc/BRIEF.md
# High-Speed Transmit Slew-Rate Calibration Sequencer

This block runs the calibration of the high-speed transmit edge rate without software stepping it through. A start request either applies a nonzero forced code at once, or runs a full measurement. The measurement turns on the ring oscillator, waits for it to settle and turns on the free-running clock. It then presents the meter window length and enables the frequency meter. It waits for the meter's valid flag, or gives up after a timeout and takes the count as it stands. The meter and then the free-running clock are switched off, the count is turned into a slew control code, the code is published, and the oscillator is switched off last.

The code is the product of the reference frequency in MHz, a coefficient and the window length, divided by the measured count and then divided by 1000, rounded to the nearest integer. Typical operands are 26 MHz and 17. The first division is a restoring divider that yields one quotient bit per clock. The rounding step compares the quotient against fixed thresholds. A count of zero yields a fallback code, and results above the code range saturate.

Top module: `hs_slew_cal`

## Requirements
- R1: During and after reset, with no start request, `osc_en`, `frck_en`, `fm_en` and `done` are low and `code` and `fm_cycles` are zero.
- R2: A start with a nonzero `force_code` sets `code` to that value and raises `done` one cycle after the start edge. No strobe toggles.
- R3: A start with `force_code` zero raises `osc_en` after the start edge. `SETTLE_CYC` cycles later, `frck_en` rises and `fm_cycles` shows `METER_CYC`. `fm_en` rises one cycle after that.
- R4: When `fm_valid` is sampled high during the wait, `fm_en` falls after that edge and `frck_en` falls one cycle later.
- R5: If `fm_valid` stays low for `TIMEOUT_CYC` cycles of `fm_en`, the wait ends as in R4 and the count on `fm_count` is used.
- R6: For a nonzero count N, `code` = min(7, floor((floor(ref_mhz*coef*METER_CYC/N) + 500) / 1000)).
- R7: A captured count of zero yields `code` = 3.
- R8: A computed value above 7 saturates `code` to 7.
- R9: `code` updates NW+1 cycles after `frck_en` falls, where NW = REF_W+COEF_W+clog2(METER_CYC+1). One cycle later `osc_en` falls and `done` is high for exactly one cycle.
- R10: A start request while a calibration is running has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Calibration request, taken only when idle |
| ref_mhz | input | REF_W (8) | Reference clock frequency in MHz, sampled at start |
| coef | input | COEF_W (8) | Slew coefficient, sampled at start |
| force_code | input | CODE_W (3) | Forced code; nonzero skips measurement |
| fm_valid | input | 1 | Meter result valid |
| fm_count | input | CNT_W (24) | Meter count |
| osc_en | output | 1 | Ring oscillator enable |
| frck_en | output | 1 | Free-running clock enable |
| fm_en | output | 1 | Frequency meter enable |
| fm_cycles | output | CYC_W (24) | Meter window length presented to the meter |
| code | output | CODE_W (3) | Slew control code |
| done | output | 1 | One-cycle completion pulse |

## Verification
Counting from the edge that samples start, a forced code and `done` are due at that edge. In a measured run, `osc_en` follows at the same edge, `frck_en` follows S edges later and `fm_en` one edge after that. Calling E the edge that ends the wait, `code` is due at E+2+NW, and `osc_en` falls and `done` pulses at E+3+NW. The bench's meter raises valid a chosen number of cycles after `fm_en`, or never for the timeout case, so E is known before each run. A timeline model built from these offsets predicts every output for every cycle. It is compared at each falling edge, away from the edges where the design changes.

// File: rtl/hs_slew_cal.sv
module hs_slew_cal #(
  parameter int REF_W       = 8,
  parameter int COEF_W      = 8,
  parameter int CNT_W       = 24,
  parameter int CODE_W      = 3,
  parameter int CYC_W       = 24,
  parameter int METER_CYC   = 1024,
  parameter int SETTLE_CYC  = 250,
  parameter int TIMEOUT_CYC = 50000,
  parameter int SR_DIV      = 1000,
  parameter int ZERO_CODE   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [REF_W-1:0]  ref_mhz,
  input  logic [COEF_W-1:0] coef,
  input  logic [CODE_W-1:0] force_code,
  input  logic              fm_valid,
  input  logic [CNT_W-1:0]  fm_count,
  output logic              osc_en,
  output logic              frck_en,
  output logic              fm_en,
  output logic [CYC_W-1:0]  fm_cycles,
  output logic [CODE_W-1:0] code,
  output logic              done
);
  localparam int NUM_W = REF_W + COEF_W + $clog2(METER_CYC + 1);
  localparam int TMAX  = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int IW    = $clog2(NUM_W);

  typedef enum logic [2:0] {S_IDLE, S_SETTLE, S_ARM, S_MEAS, S_STOP, S_DIV, S_ROUND, S_FIN} st_t;

  st_t              st;
  logic [TW-1:0]    tcnt;
  logic [IW-1:0]    it;
  logic [NUM_W-1:0] quo;
  logic [CNT_W-1:0] rem, meas;
  logic [CNT_W:0]   trial;
  logic             fits;
  logic [CODE_W-1:0] rcode;

  wire go = start && (st == S_IDLE);
  wire [NUM_W-1:0] num = NUM_W'(ref_mhz) * NUM_W'(coef) * NUM_W'(METER_CYC);

  assign trial = {rem, quo[NUM_W-1]};
  assign fits  = trial >= {1'b0, meas};

  always_comb begin
    rcode = '0;
    for (int k = 1; k < (1 << CODE_W); k++)
      if (quo >= NUM_W'(SR_DIV * k - SR_DIV / 2)) rcode = CODE_W'(k);
    if (meas == '0) rcode = CODE_W'(ZERO_CODE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  tcnt <= '0;  it <= '0;  quo <= '0;  rem <= '0;  meas <= '0;
      osc_en <= 1'b0;  frck_en <= 1'b0;  fm_en <= 1'b0;
      fm_cycles <= '0;  code <= '0;  done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          if (force_code != '0) begin
            code <= force_code;
            done <= 1'b1;
          end else begin
            osc_en <= 1'b1;
            tcnt   <= '0;
            quo    <= num;
            st     <= S_SETTLE;
          end
        end
        S_SETTLE: if (tcnt == TW'(SETTLE_CYC - 1)) begin
          frck_en   <= 1'b1;
          fm_cycles <= CYC_W'(METER_CYC);
          st        <= S_ARM;
        end else tcnt <= tcnt + 1'b1;
        S_ARM: begin
          fm_en <= 1'b1;
          tcnt  <= '0;
          st    <= S_MEAS;
        end
        S_MEAS: if (fm_valid || tcnt == TW'(TIMEOUT_CYC - 1)) begin
          meas  <= fm_count;
          fm_en <= 1'b0;
          st    <= S_STOP;
        end else tcnt <= tcnt + 1'b1;
        S_STOP: begin
          frck_en <= 1'b0;
          rem     <= '0;
          it      <= '0;
          st      <= S_DIV;
        end
        S_DIV: begin
          quo <= {quo[NUM_W-2:0], fits};
          rem <= fits ? CNT_W'(trial - {1'b0, meas}) : trial[CNT_W-1:0];
          it  <= it + 1'b1;
          if (it == IW'(NUM_W - 1)) st <= S_ROUND;
        end
        S_ROUND: begin
          code <= rcode;
          st   <= S_FIN;
        end
        S_FIN: begin
          osc_en <= 1'b0;
          done   <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_meter_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fm_en |-> (frck_en && osc_en));
  assert_frck_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frck_en |-> osc_en);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_osc_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> (done && !frck_en && !fm_en));
  assert_code_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en && st != S_ROUND) |=> $stable(code));
  assert_wait_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MEAS) |-> (tcnt < TW'(TIMEOUT_CYC)));
  assert_zero_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ROUND && meas == '0) |=> (code == CODE_W'(ZERO_CODE)));
endmodule

// File: tb/hs_slew_cal_tb.sv
module hs_slew_cal_tb;
  localparam int S  = 5;
  localparam int T  = 30;
  localparam int NW = 8 + 8 + 11;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, fm_valid = 1'b0;
  logic [7:0] ref_mhz = '0, coef = '0;
  logic [2:0] force_code = '0;
  logic [23:0] fm_count = '0;
  logic osc_en, frck_en, fm_en, done;
  logic [23:0] fm_cycles;
  logic [2:0] code;

  always #2 clk = ~clk;

  hs_slew_cal #(.SETTLE_CYC(S), .TIMEOUT_CYC(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_mhz(ref_mhz), .coef(coef),
    .force_code(force_code), .fm_valid(fm_valid), .fm_count(fm_count),
    .osc_en(osc_en), .frck_en(frck_en), .fm_en(fm_en), .fm_cycles(fm_cycles),
    .code(code), .done(done));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  int m_t0 = 0, m_force = 0, m_E = 0, m_F = 0, m_code = 0, m_prev_code = 0;
  int m_prev_cyc = 0, m_cyc_done = 0;
  bit m_active = 0;
  string m_tag = "R1";
  int lat = 1, hi = 0;
  bit lat_on = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // meter model: valid once fm_en has been high for lat cycles
  always @(posedge clk) begin
    #1;
    if (fm_en) hi++; else hi = 0;
    fm_valid = fm_en && lat_on && (hi >= lat);
  end

  function automatic int calc(int r, int c, int n);
    longint q, k;
    if (n == 0) return 3;
    q = (longint'(r) * c * 1024) / n;
    k = (q + 500) / 1000;
    return (k > 7) ? 7 : int'(k);
  endfunction

  task automatic chk(string req, string sig, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s [run %s] %s got %0d exp %0d at cycle %0d", req, m_tag, sig, got, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    int rel, e_osc, e_frck, e_fm, e_done, e_code, e_cyc;
    rel = cyc - m_t0;
    e_osc = 0; e_frck = 0; e_fm = 0; e_done = 0;
    e_code = m_prev_code; e_cyc = m_prev_cyc;
    if (!rst_n) begin
      e_code = 0; e_cyc = 0;
    end else if (m_active && rel >= 0) begin
      if (m_force != 0) begin
        e_done = (rel == 0);
        e_code = m_code;
      end else begin
        e_osc  = (rel < m_F);
        e_frck = (rel >= S) && (rel <= m_E);
        e_fm   = (rel >= S + 1) && (rel <= m_E - 1);
        e_done = (rel == m_F);
        if (rel >= m_E + 2 + NW) e_code = m_code;
        if (rel >= S) e_cyc = 1024;
      end
    end
    if (!m_active || !rst_n) begin
      chk("R1", "osc_en", osc_en, e_osc);
      chk("R1", "code", code, e_code);
    end else if (m_force != 0) begin
      chk("R2", "osc_en", osc_en, e_osc);
      chk("R2", "code", code, e_code);
    end else begin
      chk("R9", "osc_en", osc_en, e_osc);
      chk("R6", "code", code, e_code);
    end
    chk("R4", "frck_en", frck_en, e_frck);
    chk("R3", "fm_en", fm_en, e_fm);
    chk("R9", "done", done, e_done);
    chk("R3", "fm_cycles", fm_cycles, e_cyc);
  end

  task automatic run(int frc, int r, int c, int n, int l, bit lon, bit poke, string tag);
    @(posedge clk); #1;
    ref_mhz = 8'(r); coef = 8'(c); force_code = 3'(frc); fm_count = 24'(n);
    lat = l; lat_on = lon;
    m_prev_code = m_code;
    m_prev_cyc  = m_cyc_done;
    if (frc == 0) m_cyc_done = 1024;
    m_force = frc;
    m_E = S + 1 + (lon ? ((l < T) ? l : T) : T);
    m_F = (frc != 0) ? 0 : m_E + 3 + NW;
    m_code = (frc != 0) ? frc : calc(r, c, n);
    m_tag = tag;
    m_t0 = cyc + 1;
    m_active = 1;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (poke) begin
      repeat (3) @(posedge clk);
      #1; force_code = 3'd5; start = 1'b1;
      @(posedge clk); #1; start = 1'b0; force_code = 3'(frc);
      repeat (S + 4) @(posedge clk);
      #1; force_code = 3'd6; start = 1'b1;
      @(posedge clk); #1; start = 1'b0; force_code = 3'(frc);
    end
    repeat (m_F + 6) @(posedge clk);
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finish_up();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    run(0, 26, 17, 150, 10, 1, 0, "R6");
    run(0, 26, 17, 226, 3, 1, 0, "R4");
    run(0, 26, 17, 1, 1, 1, 0, "R8");
    run(0, 26, 17, 0, 5, 1, 0, "R7");
    run(0, 26, 17, 90, 0, 0, 0, "R5");
    run(6, 26, 17, 150, 4, 1, 0, "R2");
    run(0, 40, 20, 800, 6, 1, 1, "R10");
    run(0, 26, 17, 100000, 2, 1, 0, "R6");
    run(0, 255, 255, 30, 8, 1, 0, "R8");
    run(3, 26, 17, 0, 4, 1, 0, "R2");
    run(0, 26, 17, 150, 40, 1, 0, "R5");
    finish_up();
  end
endmodule